// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It walks the memory through its mandatory power-up sequence and programs the mode registers. It raises the clock enable after a quiet period, precharges all banks, and loads the four mode registers with the bank-address value each one needs. It resets the DLL, refreshes the array and steps the off-chip-driver calibration bits through their default state. When the sequence is complete it signals that normal traffic may start.

All waits are counted in clock cycles. The counts are derived from nanosecond timing parameters and a clock-period parameter, rounded up. The memory timing configuration (CAS latency, additive latency, burst length, termination value and drive strength) arrives on input pins. It is frozen at the moment the clock enable rises.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled high, `cke` is low, `csN`, `rasN`, `casN` and `weN` are all high (deselect), and `initDone` and `ready` are low.
- R2: Before `pwrStable` is seen, the bus shows deselect. Afterwards, only NOP ({csN,rasN,casN,weN}=0111) or deselect appears with `cke` low for at least T_PWRUP_NS worth of cycles. Then `cke` rises and stays high until reset.
- R3: The first command after `cke` rises is PRECHARGE ALL (0010 with addr bit 10 set). It is issued at least T_CKE_NS worth of cycles after the rise.
- R4: The non-NOP commands come in exactly this order, with the {ba1,ba0} values shown:
  - PRECHARGE ALL;
  - LOAD MODE (0000) to bank 2, then to bank 3;
  - LOAD MODE to bank 1 with calibration field 000;
  - LOAD MODE to bank 0 with DLL reset;
  - PRECHARGE ALL;
  - NUM_REFRESH REFRESH (0001) commands;
  - LOAD MODE to bank 0 without DLL reset;
  - LOAD MODE to bank 1 with calibration field 111;
  - LOAD MODE to bank 1 with calibration field 000.
  The loads to banks 2 and 3 carry an all-zero address.
- R5: A bank-1 load has this address layout:
  - bit 0 = 0 (DLL on);
  - bit 1 = drive strength (1 reduced);
  - bit 2 = rttSel[0] and bit 6 = rttSel[1] (00 off, 01 75 ohm, 10 150 ohm, 11 50 ohm);
  - bits 5:3 = additive latency in binary;
  - bits 9:7 = calibration field;
  - all other bits 0.
- R6: A bank-0 load has this address layout:
  - bits 2:0 = 010 for burst 4 or 011 for burst 8;
  - bits 6:4 = CAS latency in binary;
  - bit 8 = 1 on the first bank-0 load only;
  - bits 11:9 = WR_CODE;
  - all other bits 0.
- R7: A CAS latency below 3 is programmed as 3 and one above 6 as 6. An additive latency above 4 is programmed as 4.
- R8: After a LOAD MODE, the next command comes at least TMRD_CYC cycles later. After a PRECHARGE it comes at least T_RP_NS later, and after a REFRESH at least T_RFC_NS later.
- R9: `initDone` pulses for exactly one cycle. It comes at least TMRD_CYC cycles after the last LOAD MODE and at least DLL_LOCK_CYC cycles after the DLL-reset load.
- R10: `ready` rises together with the `initDone` pulse and stays high until reset. `cke` stays high as well.
- R11: The configuration inputs are captured on the edge where `cke` rises. Changes after that have no effect on any programmed register value.
- R12: A reset asserted in the middle of the sequence returns the block to the R1 state. A new sequence then runs in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pwrStable | input | 1 | Supplies and memory clock are stable |
| casLat | input | 3 | Requested CAS latency, cycles |
| addLat | input | 3 | Requested additive latency, cycles |
| burstLen8 | input | 1 | 1 selects burst 8, 0 burst 4 |
| rttSel | input | 2 | Termination select code |
| driveReduced | input | 1 | 1 selects reduced output drive |
| cke | output | 1 | Memory clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row address bus |
| initDone | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Level: initialization complete |

## Verification
The bench builds the block with a 4000 ps clock period and a shortened 1000 ns power-up wait (250 cycles). The other timings are 400 ns to the first precharge (100 cycles), 15 ns tRP (4 cycles), 128 ns tRFC (32 cycles), tMRD of 2, a 200-cycle DLL lock and three refreshes. With these values one full sequence takes a few hundred cycles, so several runs fit in one simulation. Because three refreshes plus the trailing loads take less than 200 cycles, the DLL lock window, not tMRD, sets when `initDone` appears, and that path is exercised. Three refreshes also show that the count is not fixed at two. Configurations just outside the legal CAS and additive latency ranges exercise the clamping.

// File: rtl/ddr2init_pkg.sv
package ddr2init_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1111
  } cmd_e;

  typedef enum logic [2:0] {
    MRK_ZERO,
    MRK_MR_DLLRST,
    MRK_MR_NORM,
    MRK_EMR_BASE,
    MRK_EMR_OCDDEF
  } mrKind_e;

  typedef struct packed {
    cmd_e        cmd;
    logic [1:0]  bankSel;
    mrKind_e     kind;
    logic        ckeOn;
    logic        capture;
    logic        done;
  } initStrobe_t;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

  function automatic int unsigned atLeast2(input int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction

endpackage

// File: rtl/ddr2init_ctrl.sv
module ddr2init_ctrl
  import ddr2init_pkg::*;
#(
  parameter int unsigned PWR_CYC     = 50000,
  parameter int unsigned CKE_CYC     = 100,
  parameter int unsigned MRD_CYC     = 2,
  parameter int unsigned RP_CYC      = 4,
  parameter int unsigned RFC_CYC     = 32,
  parameter int unsigned LOCK_CYC    = 200,
  parameter int unsigned NUM_REFRESH = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pwrStable,
  output initStrobe_t strobe
);

  localparam int unsigned CNT_W  = $clog2(PWR_CYC + CKE_CYC + RFC_CYC + 4) + 1;
  localparam int unsigned LOCK_W = $clog2(LOCK_CYC + 1) + 1;
  localparam int unsigned REF_W  = $clog2(NUM_REFRESH + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_CKEUP, S_PRE1, S_EMR2, S_EMR3, S_EMR1, S_MRDLL,
    S_PRE2, S_REF, S_MRFIN, S_OCDDEF, S_OCDEXIT, S_LOCK, S_DONE, S_READY
  } state_e;

  state_e            state, nextSt, gapNext;
  logic [CNT_W-1:0]  gapCnt;
  logic [LOCK_W-1:0] lockCnt;
  logic [REF_W-1:0]  refLeft;
  logic              doGap;
  int unsigned       gapLen;

  // Which commanded spacing follows the current state
  always_comb begin
    doGap   = 1'b0;
    gapLen  = 2;
    gapNext = S_IDLE;
    unique case (state)
      S_IDLE:    if (pwrStable) begin doGap = 1'b1; gapLen = PWR_CYC + 1; gapNext = S_CKEUP; end
      S_CKEUP:   begin doGap = 1'b1; gapLen = CKE_CYC; gapNext = S_PRE1;    end
      S_PRE1:    begin doGap = 1'b1; gapLen = RP_CYC;  gapNext = S_EMR2;    end
      S_EMR2:    begin doGap = 1'b1; gapLen = MRD_CYC; gapNext = S_EMR3;    end
      S_EMR3:    begin doGap = 1'b1; gapLen = MRD_CYC; gapNext = S_EMR1;    end
      S_EMR1:    begin doGap = 1'b1; gapLen = MRD_CYC; gapNext = S_MRDLL;   end
      S_MRDLL:   begin doGap = 1'b1; gapLen = MRD_CYC; gapNext = S_PRE2;    end
      S_PRE2:    begin doGap = 1'b1; gapLen = RP_CYC;  gapNext = S_REF;     end
      S_REF:     begin doGap = 1'b1; gapLen = RFC_CYC;
                   gapNext = (refLeft == '0) ? S_MRFIN : S_REF;             end
      S_MRFIN:   begin doGap = 1'b1; gapLen = MRD_CYC; gapNext = S_OCDDEF;  end
      S_OCDDEF:  begin doGap = 1'b1; gapLen = MRD_CYC; gapNext = S_OCDEXIT; end
      S_OCDEXIT: begin doGap = 1'b1; gapLen = MRD_CYC; gapNext = S_LOCK;    end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      nextSt  <= S_IDLE;
      gapCnt  <= '0;
      lockCnt <= '0;
      refLeft <= '0;
    end else begin
      if (state == S_MRDLL)      lockCnt <= LOCK_W'(LOCK_CYC - 1);
      else if (lockCnt != '0)    lockCnt <= lockCnt - 1'b1;

      if (state == S_PRE2)                         refLeft <= REF_W'(NUM_REFRESH - 1);
      else if (state == S_REF && refLeft != '0)    refLeft <= refLeft - 1'b1;

      if (doGap) begin
        state  <= S_GAP;
        gapCnt <= CNT_W'(gapLen - 2);
        nextSt <= gapNext;
      end else begin
        unique case (state)
          S_GAP:   if (gapCnt == '0) state <= nextSt;
                   else              gapCnt <= gapCnt - 1'b1;
          S_LOCK:  if (lockCnt == '0) state <= S_DONE;
          S_DONE:  state <= S_READY;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.cmd     = CMD_NOP;
    strobe.kind    = MRK_ZERO;
    unique case (state)
      S_IDLE:    strobe.cmd = CMD_DES;
      S_CKEUP:   begin strobe.ckeOn = 1'b1; strobe.capture = 1'b1; end
      S_PRE1,
      S_PRE2:    strobe.cmd = CMD_PRE;
      S_EMR2:    begin strobe.cmd = CMD_LMR; strobe.bankSel = 2'd2; end
      S_EMR3:    begin strobe.cmd = CMD_LMR; strobe.bankSel = 2'd3; end
      S_EMR1,
      S_OCDEXIT: begin strobe.cmd = CMD_LMR; strobe.bankSel = 2'd1; strobe.kind = MRK_EMR_BASE; end
      S_OCDDEF:  begin strobe.cmd = CMD_LMR; strobe.bankSel = 2'd1; strobe.kind = MRK_EMR_OCDDEF; end
      S_MRDLL:   begin strobe.cmd = CMD_LMR; strobe.kind = MRK_MR_DLLRST; end
      S_MRFIN:   begin strobe.cmd = CMD_LMR; strobe.kind = MRK_MR_NORM; end
      S_REF:     strobe.cmd = CMD_REF;
      S_DONE:    strobe.done = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/ddr2init_dp.sv
module ddr2init_dp
  import ddr2init_pkg::*;
#(
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned BANK_W  = 2,
  parameter logic [2:0]  WR_CODE = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  initStrobe_t       strobe,
  input  logic [2:0]        casLat,
  input  logic [2:0]        addLat,
  input  logic              burstLen8,
  input  logic [1:0]        rttSel,
  input  logic              driveReduced,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              initDone,
  output logic              ready
);

  logic [2:0]       clHeld, alHeld;
  logic             bl8Held, odsHeld;
  logic [1:0]       rttHeld;
  logic [2:0]       clLegal, alLegal;
  logic [ROW_W-1:0] addrNext;
  cmd_e             cmdReg;
  logic [1:0]       baReg;

  // Range limiting of the latency requests
  always_comb begin
    if (casLat < 3'd3)      clLegal = 3'd3;
    else if (casLat > 3'd6) clLegal = 3'd6;
    else                    clLegal = casLat;
    alLegal = (addLat > 3'd4) ? 3'd4 : addLat;
  end

  always_comb begin
    addrNext = '0;
    if (strobe.cmd == CMD_PRE) addrNext[10] = 1'b1;
    unique case (strobe.kind)
      MRK_MR_DLLRST, MRK_MR_NORM: begin
        addrNext[2:0]  = bl8Held ? 3'b011 : 3'b010;
        addrNext[6:4]  = clHeld;
        addrNext[8]    = (strobe.kind == MRK_MR_DLLRST);
        addrNext[11:9] = WR_CODE;
      end
      MRK_EMR_BASE, MRK_EMR_OCDDEF: begin
        addrNext[1]   = odsHeld;
        addrNext[2]   = rttHeld[0];
        addrNext[5:3] = alHeld;
        addrNext[6]   = rttHeld[1];
        addrNext[9:7] = (strobe.kind == MRK_EMR_OCDDEF) ? 3'b111 : 3'b000;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clHeld   <= 3'd3;
      alHeld   <= '0;
      bl8Held  <= 1'b0;
      odsHeld  <= 1'b0;
      rttHeld  <= '0;
      cke      <= 1'b0;
      cmdReg   <= CMD_DES;
      baReg    <= '0;
      addr     <= '0;
      initDone <= 1'b0;
      ready    <= 1'b0;
    end else begin
      if (strobe.capture) begin
        clHeld  <= clLegal;
        alHeld  <= alLegal;
        bl8Held <= burstLen8;
        odsHeld <= driveReduced;
        rttHeld <= rttSel;
      end
      if (strobe.ckeOn) cke <= 1'b1;
      cmdReg   <= strobe.cmd;
      baReg    <= strobe.bankSel;
      addr     <= addrNext;
      initDone <= strobe.done;
      if (strobe.done) ready <= 1'b1;
    end
  end

  assign {csN, rasN, casN, weN} = cmdReg;

  generate
    if (BANK_W > 2) begin : g_baWide
      assign ba = {{(BANK_W-2){1'b0}}, baReg};
    end else begin : g_baNarrow
      assign ba = baReg;
    end
  endgenerate

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_PWRUP_NS    = 200000,
  parameter int unsigned T_CKE_NS      = 400,
  parameter int unsigned T_RP_NS       = 15,
  parameter int unsigned T_RFC_NS      = 128,
  parameter int unsigned TMRD_CYC      = 2,
  parameter int unsigned DLL_LOCK_CYC  = 200,
  parameter int unsigned NUM_REFRESH   = 2,
  parameter logic [2:0]  WR_CODE       = 3'b010,
  parameter int unsigned ROW_W         = 14,
  parameter int unsigned BANK_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrStable,
  input  logic [2:0]        casLat,
  input  logic [2:0]        addLat,
  input  logic              burstLen8,
  input  logic [1:0]        rttSel,
  input  logic              driveReduced,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              initDone,
  output logic              ready
);

  localparam int unsigned PWR_C  = ns2cyc(T_PWRUP_NS, CLK_PERIOD_PS);
  localparam int unsigned CKE_C  = atLeast2(ns2cyc(T_CKE_NS, CLK_PERIOD_PS));
  localparam int unsigned RP_C   = atLeast2(ns2cyc(T_RP_NS, CLK_PERIOD_PS));
  localparam int unsigned RFC_C  = atLeast2(ns2cyc(T_RFC_NS, CLK_PERIOD_PS));
  localparam int unsigned MRD_C  = atLeast2(TMRD_CYC);
  localparam int unsigned LOCK_C = (DLL_LOCK_CYC < 1) ? 1 : DLL_LOCK_CYC;
  localparam int unsigned REF_N  = atLeast2(NUM_REFRESH);

  initStrobe_t strobe;

  ddr2init_ctrl #(
    .PWR_CYC(PWR_C), .CKE_CYC(CKE_C), .MRD_CYC(MRD_C), .RP_CYC(RP_C),
    .RFC_CYC(RFC_C), .LOCK_CYC(LOCK_C), .NUM_REFRESH(REF_N)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pwrStable(pwrStable), .strobe(strobe)
  );

  ddr2init_dp #(.ROW_W(ROW_W), .BANK_W(BANK_W), .WR_CODE(WR_CODE)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .casLat(casLat), .addLat(addLat), .burstLen8(burstLen8),
    .rttSel(rttSel), .driveReduced(driveReduced),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .initDone(initDone), .ready(ready)
  );

endmodule

// File: rtl/ddr2init_chk.sv
module ddr2init_chk (
  input logic clk,
  input logic rst,
  input logic cke,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic preA10,
  input logic initDone,
  input logic ready
);

  logic isNop, isLmr, isPre;
  assign isNop = ({csN, rasN, casN, weN} == 4'b0111);
  assign isLmr = ({csN, rasN, casN, weN} == 4'b0000);
  assign isPre = ({csN, rasN, casN, weN} == 4'b0010);

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst) cke |=> cke);

  // R2
  quiet_before_cke_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (csN || isNop));

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (rst) isPre |-> preA10);

  // R8
  lmr_spacing_chk: assert property (@(posedge clk) disable iff (rst) isLmr |=> isNop);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) initDone |=> !initDone);

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst) ready |=> ready);

  // R10
  ready_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    initDone |-> ready);

  // R10
  done_needs_cke_chk: assert property (@(posedge clk) disable iff (rst) ready |-> cke);

endmodule

bind ddr2_init_seq ddr2init_chk u_chk (
  .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .preA10(addr[10]), .initDone(initDone), .ready(ready)
);

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;

  localparam int PERIOD_PS = 4000;
  localparam int PWR_C  = 250;
  localparam int CKE_C  = 100;
  localparam int RP_C   = 4;
  localparam int RFC_C  = 32;
  localparam int MRD_C  = 2;
  localparam int LOCK_C = 200;
  localparam logic [2:0] WR = 3'b010;

  localparam int K_PRE = 0, K_ZERO = 1, K_EMR = 2, K_OCD = 3, K_MRDLL = 4, K_MRFIN = 5, K_REF = 6;

  // {cmd[3:0], ba[1:0], kind[3:0], minGap[15:0]}
  localparam logic [25:0] SEQ [12] = '{
    {4'b0010, 2'd0, 4'(K_PRE),   16'(CKE_C)},
    {4'b0000, 2'd2, 4'(K_ZERO),  16'(RP_C)},
    {4'b0000, 2'd3, 4'(K_ZERO),  16'(MRD_C)},
    {4'b0000, 2'd1, 4'(K_EMR),   16'(MRD_C)},
    {4'b0000, 2'd0, 4'(K_MRDLL), 16'(MRD_C)},
    {4'b0010, 2'd0, 4'(K_PRE),   16'(MRD_C)},
    {4'b0001, 2'd0, 4'(K_REF),   16'(RP_C)},
    {4'b0001, 2'd0, 4'(K_REF),   16'(RFC_C)},
    {4'b0001, 2'd0, 4'(K_REF),   16'(RFC_C)},
    {4'b0000, 2'd0, 4'(K_MRFIN), 16'(RFC_C)},
    {4'b0000, 2'd1, 4'(K_OCD),   16'(MRD_C)},
    {4'b0000, 2'd1, 4'(K_EMR),   16'(MRD_C)}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrStable = 1'b0;
  logic [2:0] casLat = 3'd4, addLat = 3'd0;
  logic burstLen8 = 1'b0, driveReduced = 1'b0;
  logic [1:0] rttSel = 2'b00;
  logic cke, csN, rasN, casN, weN, initDone, ready;
  logic [1:0] ba;
  logic [13:0] addr;
  int cyc = 0;
  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #2ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_init_seq #(
    .CLK_PERIOD_PS(PERIOD_PS), .T_PWRUP_NS(1000), .T_CKE_NS(400), .T_RP_NS(15),
    .T_RFC_NS(128), .TMRD_CYC(2), .DLL_LOCK_CYC(LOCK_C), .NUM_REFRESH(3),
    .WR_CODE(WR), .ROW_W(14), .BANK_W(2)
  ) u_dut (
    .clk(clk), .rst(rst), .pwrStable(pwrStable), .casLat(casLat), .addLat(addLat),
    .burstLen8(burstLen8), .rttSel(rttSel), .driveReduced(driveReduced),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .initDone(initDone), .ready(ready)
  );

  wire [3:0] cmdBus = {csN, rasN, casN, weN};

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] expAddr(input int kind, input int cl, input int al,
                                          input bit bl8, input logic [1:0] rtt, input bit ods);
    int c, a;
    logic [13:0] w;
    c = (cl < 3) ? 3 : ((cl > 6) ? 6 : cl);
    a = (al > 4) ? 4 : al;
    w = '0;
    case (kind)
      K_PRE: w[10] = 1'b1;
      K_MRDLL, K_MRFIN: begin
        w[2:0] = bl8 ? 3'b011 : 3'b010;
        w[6:4] = 3'(c);
        w[8] = (kind == K_MRDLL);
        w[11:9] = WR;
      end
      K_EMR, K_OCD: begin
        w[1] = ods; w[2] = rtt[0]; w[5:3] = 3'(a); w[6] = rtt[1];
        w[9:7] = (kind == K_OCD) ? 3'b111 : 3'b000;
      end
      default: ;
    endcase
    return w;
  endfunction

  task automatic checkResetState(input string tag);
    chk(cke == 1'b0, "R1", {tag, " cke"}, int'(cke), 0);
    chk(cmdBus == 4'b1111, "R1", {tag, " deselect"}, int'(cmdBus), 15);
    chk(initDone == 1'b0 && ready == 1'b0, "R1", {tag, " done/ready"}, int'({initDone, ready}), 0);
  endtask

  task automatic runInit(input int cl, input int al, input bit bl8, input logic [1:0] rtt,
                         input bit ods, input bit changeLater);
    int nopCnt, ckeCyc, lastCyc, dllCyc, lmCyc, doneCyc;
    bit quiet, ckeKept;
    rst = 1'b1; pwrStable = 1'b0;
    casLat = 3'(cl); addLat = 3'(al); burstLen8 = bl8; rttSel = rtt; driveReduced = ods;
    repeat (2) @(negedge clk);
    checkResetState("in reset");
    rst = 1'b0;
    quiet = 1'b1;
    repeat (10) begin @(negedge clk); if (cmdBus != 4'b1111 || cke) quiet = 1'b0; end
    chk(quiet, "R2", "deselect before power stable", int'(quiet), 1);
    pwrStable = 1'b1;
    nopCnt = 0; quiet = 1'b1;
    do begin
      @(negedge clk);
      if (!cke) begin
        if (cmdBus == 4'b0111) nopCnt++;
        else if (cmdBus != 4'b1111) quiet = 1'b0;
      end
    end while (!cke);
    ckeCyc = cyc;
    chk(quiet, "R2", "only NOP/deselect while cke low", int'(quiet), 1);
    chk(nopCnt >= PWR_C, "R2", "NOP cycles before cke", nopCnt, PWR_C);
    if (changeLater) begin
      casLat = 3'd6; addLat = 3'd1; burstLen8 = ~bl8; rttSel = ~rtt; driveReduced = ~ods;
    end
    lastCyc = ckeCyc; dllCyc = 0; lmCyc = 0; ckeKept = 1'b1;
    for (int i = 0; i < 12; i++) begin
      logic [25:0] e;
      string tag;
      e = SEQ[i];
      tag = $sformatf("step %0d", i);
      do begin
        @(negedge clk);
        if (!cke) ckeKept = 1'b0;
      end while (cmdBus == 4'b0111);
      chk(cmdBus == e[25:22], (i == 0) ? "R3" : "R4", {tag, " command"}, int'(cmdBus), int'(e[25:22]));
      chk(ba == e[21:20], "R4", {tag, " bank"}, int'(ba), int'(e[21:20]));
      if (int'(e[19:16]) != K_REF)
        chk(addr == expAddr(int'(e[19:16]), cl, al, bl8, rtt, ods),
            (int'(e[19:16]) >= K_EMR && int'(e[19:16]) <= K_OCD) ? "R5_R7_R11" : "R6_R7_R11",
            {tag, " address"}, int'(addr), int'(expAddr(int'(e[19:16]), cl, al, bl8, rtt, ods)));
      chk(cyc - lastCyc >= int'(e[15:0]), (i == 0) ? "R3" : "R8", {tag, " spacing"},
          cyc - lastCyc, int'(e[15:0]));
      if (int'(e[19:16]) == K_MRDLL) dllCyc = cyc;
      if (e[25:22] == 4'b0000) lmCyc = cyc;
      lastCyc = cyc;
    end
    chk(ckeKept, "R2", "cke held high during sequence", int'(ckeKept), 1);
    while (!initDone) @(negedge clk);
    doneCyc = cyc;
    chk(doneCyc - lmCyc >= MRD_C, "R9", "done after last load", doneCyc - lmCyc, MRD_C);
    chk(doneCyc - dllCyc >= LOCK_C, "R9", "done after DLL lock", doneCyc - dllCyc, LOCK_C);
    chk(ready == 1'b1, "R10", "ready with done", int'(ready), 1);
    @(negedge clk);
    chk(initDone == 1'b0, "R9", "done single cycle", int'(initDone), 0);
    repeat (20) @(negedge clk);
    chk(ready && cke, "R10", "ready and cke held", int'({ready, cke}), 3);
  endtask

  initial begin
    // R1, R2 .. R11 across three configurations; R7 clamp, R11 late change
    runInit(5, 2, 1'b1, 2'b01, 1'b1, 1'b0);
    runInit(2, 6, 1'b0, 2'b11, 1'b0, 1'b1);
    // R12: reset in the middle of the sequence
    rst = 1'b1; pwrStable = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; pwrStable = 1'b1;
    while (!cke) @(negedge clk);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(cke == 1'b0 && cmdBus == 4'b1111 && !ready, "R12", "mid-sequence reset state",
        int'({cke, cmdBus, ready}), 30);
    runInit(7, 0, 1'b0, 2'b10, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule